// File: doc/BRIEF.md
# Auxiliary Memory Bank and Display Switch Controller

This block holds the mode flags of an 8-bit computer that has two 64 KB RAM banks, a main one and an auxiliary one. The CPU changes a flag by touching an address in a small window at the base of the I/O space. Some switches respond only to writes. The display switches respond to any access. From the flags and the current CPU address the block gives two selects: one names the bank a read at that address uses, the other names the bank a write uses. It also gives the displayed page and the raw flags to a video generator.

The page switch has two jobs. With the banked-store flag clear, it picks which display page is shown. With banked-store set, the displayed page stays 0, and the page switch instead moves the text window between the banks. It moves the high-resolution window as well, but only while high-resolution mode is on. Outside those windows, reads follow the aux-read flag and writes follow the aux-write flag. The RAM arrays, video timing, language-card banking and slot ROM are outside this block.

Top module: `auxmem_switch_ctrl`

## Requirements
- R1: A write to 0xC001 sets the banked-store flag (flags_o bit 0) and a write to 0xC000 clears it; a read of either address changes nothing.
- R2: Writes to 0xC003/0xC002 set/clear the aux-read flag (flags_o bit 1), and writes to 0xC005/0xC004 set/clear the aux-write flag (flags_o bit 2). Reads of these addresses change nothing.
- R3: Any access, read or write, to an odd address in 0xC051–0xC057 sets one flag, and the even address below it clears the same flag. The flags are text (0xC050/0xC051, bit 3), mixed (0xC052/0xC053, bit 4), page-two (0xC054/0xC055, bit 5) and high-resolution (0xC056/0xC057, bit 6).
- R4: While reset is asserted, and after it is released, every flag is 0, disp_page is 0, and both selects name main RAM (0).
- R5: An access to the text or mixed switches changes only that flag; disp_page and both selects keep their values.
- R6: With banked-store clear, disp_page equals the page-two flag, and page-two has no effect on bank routing.
- R7: With banked-store set, disp_page is 0, and reads and writes in the text window 0x0400–0x07FF both select the auxiliary bank exactly when page-two is set.
- R8: In the high-resolution window 0x2000–0x3FFF, while both banked-store and high-resolution are set, reads and writes select aux exactly when page-two is set. In every other case, reads in that window follow aux-read and writes follow aux-write.
- R9: At any other address below 0xC000, rd_sel_aux follows aux-read and wr_sel_aux follows aux-write. At addresses from 0xC000 upward, both selects are 0.
- R10: A flag changes only on the rising clock edge that accepts a valid access. Outputs show the new value from that edge onward. With cpu_valid low, nothing changes.
- R11: Accesses to other addresses in the I/O space, such as 0xC006 or 0xC058, change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, is released synchronously |
| cpu_valid | input | 1 | A CPU access is present this cycle |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | CPU address; it is used both for switch decoding and for bank routing |
| rd_sel_aux | output | 1 | A read at cpu_addr uses the auxiliary bank (1) or main (0) |
| wr_sel_aux | output | 1 | A write at cpu_addr uses the auxiliary bank (1) or main (0) |
| disp_page | output | 1 | Displayed page number, 0 or 1 |
| flags_o | output | 7 | Mode flags, in the bit positions given in R1–R3 |

## Verification
The assertions check properties that hold on every cycle:
- a set strobe is followed by the set flag;
- an idle cycle leaves all flags stable;
- a read never strikes a write-only switch;
- at most one switch strobe fires per cycle;
- the I/O space always routes to main;
- the text window follows page-two while banked-store is set;
- a text or mixed access leaves the displayed page alone.

The interplay among banked-store, high-resolution and page-two across whole sequences is shown only by the bench's scenarios. These cover the high-resolution window falling back to the aux-read and aux-write flags when high-resolution is cleared, reads that are ignored, unused switch addresses, and reset asserted in the middle of a run.

// File: rtl/auxmem_pkg.sv
package auxmem_pkg;
  localparam int NFLAG     = 7;
  localparam int MEM_GROUP = 3;  // write-only switch pairs
  localparam int VID_GROUP = 4;  // any-access switch pairs

  // Flag positions; the decoder maps switch pair k onto flag k
  localparam int FLG_STORE = 0;
  localparam int FLG_RDAUX = 1;
  localparam int FLG_WRAUX = 2;
  localparam int FLG_TEXT  = 3;
  localparam int FLG_MIXED = 4;
  localparam int FLG_PAGE  = 5;
  localparam int FLG_HIRES = 6;

  typedef enum logic [1:0] {
    RGN_GENERAL = 2'd0,
    RGN_TEXT    = 2'd1,
    RGN_HIRES   = 2'd2,
    RGN_IO      = 2'd3
  } region_e;
endpackage

// File: rtl/auxmem_rst_sync.sv
module auxmem_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/auxmem_switch_decode.sv
module auxmem_switch_decode
  import auxmem_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int unsigned IO_BASE    = 'hC000,
  parameter int unsigned MEM_SW_OFS = 'h00,
  parameter int unsigned VID_SW_OFS = 'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [NFLAG-1:0]  set_stb,
  output logic [NFLAG-1:0]  clr_stb
);
  // Write-only switch pairs: even address clears, odd address sets
  for (genvar g = 0; g < MEM_GROUP; g++) begin : g_mem
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(IO_BASE + MEM_SW_OFS + 2*g);
    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(IO_BASE + MEM_SW_OFS + 2*g + 1);
    assign clr_stb[g] = cpu_valid && cpu_write && (cpu_addr == CLR_A);
    assign set_stb[g] = cpu_valid && cpu_write && (cpu_addr == SET_A);
  end

  // Any-access switch pairs
  for (genvar v = 0; v < VID_GROUP; v++) begin : g_vid
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(IO_BASE + VID_SW_OFS + 2*v);
    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(IO_BASE + VID_SW_OFS + 2*v + 1);
    assign clr_stb[MEM_GROUP+v] = cpu_valid && (cpu_addr == CLR_A);
    assign set_stb[MEM_GROUP+v] = cpu_valid && (cpu_addr == SET_A);
  end

  // R11
  stb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_stb, clr_stb}));

  // R2
  rd_no_mem_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_write |-> (set_stb[MEM_GROUP-1:0] == '0) && (clr_stb[MEM_GROUP-1:0] == '0));
endmodule

// File: rtl/auxmem_flag_regs.sv
module auxmem_flag_regs
  import auxmem_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_valid,
  input  logic [NFLAG-1:0] set_stb,
  input  logic [NFLAG-1:0] clr_stb,
  output logic [NFLAG-1:0] flags_q
);
  logic [NFLAG-1:0] flags_d;
  logic             flags_en;

  always_comb begin
    flags_en = cpu_valid;
    flags_d  = (flags_q & ~clr_stb) | set_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_chk
    // R3
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_stb[i] |=> flags_q[i]);
    // R3
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stb[i] |=> !flags_q[i]);
  end

  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_valid |=> $stable(flags_q));
endmodule

// File: rtl/auxmem_bank_route.sv
module auxmem_bank_route
  import auxmem_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int unsigned IO_BASE  = 'hC000,
  parameter int unsigned TEXT_LO  = 'h0400,
  parameter int unsigned TEXT_HI  = 'h07FF,
  parameter int unsigned HIRES_LO = 'h2000,
  parameter int unsigned HIRES_HI = 'h3FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [NFLAG-1:0]  flags_q,
  output logic              rd_sel_aux,
  output logic              wr_sel_aux
);
  localparam logic [ADDR_W-1:0] IO_A  = ADDR_W'(IO_BASE);
  localparam logic [ADDR_W-1:0] TX_LO = ADDR_W'(TEXT_LO);
  localparam logic [ADDR_W-1:0] TX_HI = ADDR_W'(TEXT_HI);
  localparam logic [ADDR_W-1:0] HG_LO = ADDR_W'(HIRES_LO);
  localparam logic [ADDR_W-1:0] HG_HI = ADDR_W'(HIRES_HI);

  region_e region;
  logic    store_txt;
  logic    store_hgr;

  always_comb begin
    if (cpu_addr >= IO_A)                            region = RGN_IO;
    else if (cpu_addr >= TX_LO && cpu_addr <= TX_HI) region = RGN_TEXT;
    else if (cpu_addr >= HG_LO && cpu_addr <= HG_HI) region = RGN_HIRES;
    else                                             region = RGN_GENERAL;
  end

  always_comb begin
    store_txt = flags_q[FLG_STORE];
    store_hgr = flags_q[FLG_STORE] && flags_q[FLG_HIRES];
    unique case (region)
      RGN_IO: begin
        rd_sel_aux = 1'b0;
        wr_sel_aux = 1'b0;
      end
      RGN_TEXT: begin
        rd_sel_aux = store_txt ? flags_q[FLG_PAGE] : flags_q[FLG_RDAUX];
        wr_sel_aux = store_txt ? flags_q[FLG_PAGE] : flags_q[FLG_WRAUX];
      end
      RGN_HIRES: begin
        rd_sel_aux = store_hgr ? flags_q[FLG_PAGE] : flags_q[FLG_RDAUX];
        wr_sel_aux = store_hgr ? flags_q[FLG_PAGE] : flags_q[FLG_WRAUX];
      end
      default: begin
        rd_sel_aux = flags_q[FLG_RDAUX];
        wr_sel_aux = flags_q[FLG_WRAUX];
      end
    endcase
  end

  // R9
  io_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr >= IO_A) |-> (!rd_sel_aux && !wr_sel_aux));

  // R7
  text_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[FLG_STORE] && cpu_addr >= TX_LO && cpu_addr <= TX_HI)
      |-> (rd_sel_aux == flags_q[FLG_PAGE]) && (wr_sel_aux == flags_q[FLG_PAGE]));
endmodule

// File: rtl/auxmem_switch_ctrl.sv
module auxmem_switch_ctrl
  import auxmem_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          SYNC_STG   = 2,
  parameter int unsigned IO_BASE    = 'hC000,
  parameter int unsigned MEM_SW_OFS = 'h00,
  parameter int unsigned VID_SW_OFS = 'h50,
  parameter int unsigned TEXT_LO    = 'h0400,
  parameter int unsigned TEXT_HI    = 'h07FF,
  parameter int unsigned HIRES_LO   = 'h2000,
  parameter int unsigned HIRES_HI   = 'h3FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              rd_sel_aux,
  output logic              wr_sel_aux,
  output logic              disp_page,
  output logic [NFLAG-1:0]  flags_o
);
  localparam logic [ADDR_W-1:0] TXT_SW_LO = ADDR_W'(IO_BASE + VID_SW_OFS);
  localparam logic [ADDR_W-1:0] TXT_SW_HI = ADDR_W'(IO_BASE + VID_SW_OFS + 3);

  logic             rst_sync_n;
  logic [NFLAG-1:0] set_stb;
  logic [NFLAG-1:0] clr_stb;
  logic [NFLAG-1:0] flags_q;

  auxmem_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  auxmem_switch_decode #(
    .ADDR_W(ADDR_W), .IO_BASE(IO_BASE),
    .MEM_SW_OFS(MEM_SW_OFS), .VID_SW_OFS(VID_SW_OFS)
  ) u_dec (
    .clk(clk), .rst_n(rst_sync_n), .cpu_valid(cpu_valid),
    .cpu_write(cpu_write), .cpu_addr(cpu_addr),
    .set_stb(set_stb), .clr_stb(clr_stb)
  );

  auxmem_flag_regs u_flags (
    .clk(clk), .rst_n(rst_sync_n), .cpu_valid(cpu_valid),
    .set_stb(set_stb), .clr_stb(clr_stb), .flags_q(flags_q)
  );

  auxmem_bank_route #(
    .ADDR_W(ADDR_W), .IO_BASE(IO_BASE),
    .TEXT_LO(TEXT_LO), .TEXT_HI(TEXT_HI),
    .HIRES_LO(HIRES_LO), .HIRES_HI(HIRES_HI)
  ) u_route (
    .clk(clk), .rst_n(rst_sync_n), .cpu_addr(cpu_addr), .flags_q(flags_q),
    .rd_sel_aux(rd_sel_aux), .wr_sel_aux(wr_sel_aux)
  );

  // The page switch picks the shown page only while banked-store is off
  always_comb begin
    disp_page = flags_q[FLG_PAGE] && !flags_q[FLG_STORE];
    flags_o   = flags_q;
  end

  // R5
  txt_mix_page_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_valid && cpu_addr >= TXT_SW_LO && cpu_addr <= TXT_SW_HI) |=> $stable(disp_page));
endmodule

// File: tb/auxmem_switch_ctrl_tb_top.sv
module auxmem_switch_ctrl_tb_top;
  localparam int NVEC = 20;

  typedef struct packed {
    logic        valid;
    logic        we;
    logic [15:0] addr;
    logic [15:0] probe;
    logic [6:0]  flags;  // {hires,page,mixed,text,wraux,rdaux,store}
    logic        rd;
    logic        wr;
    logic        pg;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b1, 16'hC003, 16'h1000, 7'b0000010, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 aux-read on
    '{1'b1, 1'b1, 16'hC005, 16'h0400, 7'b0000110, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 text follows rd/wr
    '{1'b1, 1'b0, 16'hC002, 16'h1000, 7'b0000110, 1'b1, 1'b1, 1'b0, 4'd2},  // R2 read ignored
    '{1'b1, 1'b1, 16'hC002, 16'h2000, 7'b0000100, 1'b0, 1'b1, 1'b0, 4'd9},  // R9
    '{1'b1, 1'b1, 16'hC004, 16'h2000, 7'b0000000, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
    '{1'b1, 1'b0, 16'hC055, 16'h0400, 7'b0100000, 1'b0, 1'b0, 1'b1, 4'd6},  // R6 page shown
    '{1'b1, 1'b1, 16'hC051, 16'h0400, 7'b0101000, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 text on (write)
    '{1'b1, 1'b0, 16'hC053, 16'h2000, 7'b0111000, 1'b0, 1'b0, 1'b1, 4'd3},  // R3 mixed on (read)
    '{1'b1, 1'b0, 16'hC001, 16'h0400, 7'b0111000, 1'b0, 1'b0, 1'b1, 4'd1},  // R1 read ignored
    '{1'b1, 1'b1, 16'hC001, 16'h0400, 7'b0111001, 1'b1, 1'b1, 1'b0, 4'd7},  // R7 text to aux
    '{1'b1, 1'b1, 16'hC006, 16'h2000, 7'b0111001, 1'b0, 1'b0, 1'b0, 4'd11}, // R11 unused
    '{1'b1, 1'b0, 16'hC057, 16'h2000, 7'b1111001, 1'b1, 1'b1, 1'b0, 4'd8},  // R8 hires to aux
    '{1'b1, 1'b0, 16'hC054, 16'h3FFF, 7'b1011001, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 page off
    '{1'b1, 1'b1, 16'hC003, 16'h0400, 7'b1011011, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 text ignores rd
    '{1'b1, 1'b1, 16'hC058, 16'h2000, 7'b1011011, 1'b0, 1'b0, 1'b0, 4'd11}, // R11 unused
    '{1'b1, 1'b0, 16'hC056, 16'h2000, 7'b0011011, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 hires off
    '{1'b1, 1'b0, 16'hC050, 16'h07FF, 7'b0010011, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 text off
    '{1'b1, 1'b1, 16'hC000, 16'h07FF, 7'b0010010, 1'b1, 1'b0, 1'b0, 4'd1},  // R1 store off
    '{1'b1, 1'b0, 16'hC052, 16'hC000, 7'b0000010, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 I/O is main
    '{1'b1, 1'b0, 16'hC055, 16'h8000, 7'b0100010, 1'b1, 1'b0, 1'b1, 4'd6}   // R6
  };

  logic        clk;
  logic        rst_n;
  logic        cpu_valid;
  logic        cpu_write;
  logic [15:0] cpu_addr;
  logic        rd_sel_aux;
  logic        wr_sel_aux;
  logic        disp_page;
  logic [6:0]  flags_o;

  int checks;
  int errors;

  auxmem_switch_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .rd_sel_aux(rd_sel_aux), .wr_sel_aux(wr_sel_aux),
    .disp_page(disp_page), .flags_o(flags_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] outs();
    return {flags_o, rd_sel_aux, wr_sel_aux, disp_page};
  endfunction

  task automatic access(input logic v, input logic we, input logic [15:0] a,
                        input logic [15:0] probe);
    @(negedge clk);
    cpu_valid = v;
    cpu_write = we;
    cpu_addr  = a;
    @(negedge clk);
    cpu_valid = 1'b0;
    cpu_write = 1'b0;
    cpu_addr  = probe;
    #1;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks    = 0;
    errors    = 0;
    rst_n     = 1'b0;
    cpu_valid = 1'b0;
    cpu_write = 1'b0;
    cpu_addr  = 16'h0400;
    repeat (3) @(negedge clk);
    #1;
    check("R4 in reset", outs(), 10'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R4 after release", outs(), 10'b0);

    for (int i = 0; i < NVEC; i++) begin
      access(VECS[i].valid, VECS[i].we, VECS[i].addr, VECS[i].probe);
      check($sformatf("R%0d vec %0d", VECS[i].req, i), outs(),
            {VECS[i].flags, VECS[i].rd, VECS[i].wr, VECS[i].pg});
    end

    // R10: a strobe with cpu_valid low does nothing
    access(1'b0, 1'b1, 16'hC001, 16'h8000);
    check("R10 idle write", outs(), {7'b0100010, 1'b1, 1'b0, 1'b1});

    // R10: the flag is still old before the accepting edge and new after it
    @(negedge clk);
    cpu_valid = 1'b1;
    cpu_write = 1'b1;
    cpu_addr  = 16'hC001;
    #1;
    check("R10 before edge", {flags_o, 3'b000}, {7'b0100010, 3'b000});
    @(negedge clk);
    cpu_valid = 1'b0;
    cpu_addr  = 16'h0400;
    #1;
    check("R10 after edge", outs(), {7'b0100011, 1'b1, 1'b1, 1'b0});

    // R4: asynchronous reset in the middle of a run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R4 mid-run reset", outs(), 10'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    access(1'b1, 1'b1, 16'hC003, 16'h1000);
    check("R2 after re-reset", outs(), {7'b0000010, 1'b1, 1'b0, 1'b0});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule